// File: doc/BRIEF.md
# Timer Count-Enable Front End

This block decides when a 16-bit timer channel may advance. A configuration write picks one of several counting sources: one of the internal clock-enable strobes, the external event pin as is, or the external event pin inverted. For an internal source, a power-of-two prescaler thins the selected strobes. For an external source, the pin is brought into the system clock domain and its edges are detected. The result is a one-cycle `cnt_en_o` strobe that the counter datapath uses as its advance qualifier.

Two conditions can suspend the strobe. In the low-power sleep state, the per-source stop bit for the chosen source decides whether counting halts. In the debug-halt state, the run-in-debug configuration bit decides. While counting is suspended, the prescaler phase and the external dummy-edge progress are frozen, so counting carries on where it stopped once the condition clears. After a source write, the external path throws away two qualifying edges and counts from the third.

Top module: `tclk_front`

## Requirements
- R1: After reset, `cnt_en_o` is 0 and the configuration is source 0, division code 0 and run-in-debug 0. With that configuration, every strobe on `src_tick_i[0]` yields one `cnt_en_o` pulse.
- R2: Source codes 0 to 3 select `src_tick_i[code]`. Division code N yields one pulse for every 2^N selected strobes. Strobes on unselected inputs have no effect.
- R3: With division code 0, a strobe sampled at clock edge k gives `cnt_en_o` high for exactly the cycle that follows edge k.
- R4: Source code 4 counts rising edges of `ext_pin_i`. Falling edges are not counted.
- R5: Source code 5 counts falling edges of `ext_pin_i`. Rising edges are not counted.
- R6: After any configuration write, the first two qualifying external edges produce no pulse. Every qualifying edge from the third onward produces one pulse.
- R7: The division code has no effect when source code 4 or 5 is selected.
- R8: While `sleep_i`=1 and the stop bit of the selected source is 1, no pulses are issued and the prescaler phase is held. The stop bit is `sleep_stop_i[code]` for codes 0 to 3 and `sleep_stop_i[4]` for the external codes. Counting resumes from the held phase when `sleep_i` returns to 0.
- R9: While `sleep_i`=1 and the selected source's stop bit is 0, counting continues unchanged. Stop bits of unselected sources have no effect.
- R10: While `debug_i`=1 with run-in-debug 0, no pulses are issued and the state is held. With run-in-debug 1, counting continues.
- R11: Source codes 6 and 7 never produce a pulse. An external pulse never lasts more than one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_src | input | 3 | Source code written on `cfg_we` |
| cfg_div | input | 4 | Division code written on `cfg_we` |
| cfg_dbrun | input | 1 | Run-in-debug bit written on `cfg_we` |
| sleep_i | input | 1 | Sleep state indicator |
| debug_i | input | 1 | Debug halt indicator |
| sleep_stop_i | input | 5 | Per-source stop-in-sleep bits; index 4 covers both external codes |
| src_tick_i | input | 4 | Internal clock-enable strobes |
| ext_pin_i | input | 1 | Asynchronous external event pin |
| cnt_en_o | output | 1 | One-cycle count-enable pulse |

## Verification
The hardest case to reach is proving that the prescaler phase is held, not just that pulses stop, while counting is suspended. The stimulus first puts the prescaler part-way through a period. It then applies many selected strobes during sleep or debug, chosen so that a free-running prescaler would have reached a different phase. It then checks that exactly the strobes left in the original period bring the next pulse. The dummy-edge rule is reached by writing the source code, then stepping the pin through slow, well-separated edges and counting pulses per edge.

// File: rtl/tclk_pkg.sv
package tclk_pkg;

    localparam int NUM_INT   = 4;
    localparam int SRC_W     = 3;
    localparam int DIV_W     = 4;
    localparam int PS_W      = (1 << DIV_W) - 1;
    localparam int IDX_W     = $clog2(NUM_INT);
    localparam int NUM_STOP  = NUM_INT + 1;
    localparam int DUMMY_N   = 2;

    localparam logic [SRC_W-1:0] SRC_PIN     = 3'd4;
    localparam logic [SRC_W-1:0] SRC_PIN_INV = 3'd5;

    typedef enum logic [1:0] {
        KIND_INT  = 2'd0,
        KIND_EXT  = 2'd1,
        KIND_NONE = 2'd2
    } src_kind_e;

    typedef struct packed {
        logic [SRC_W-1:0] src;
        logic [DIV_W-1:0] div;
        logic             dbrun;
    } tclk_cfg_t;

    function automatic src_kind_e kind_of(input logic [SRC_W-1:0] s);
        if (int'(s) < NUM_INT)                    return KIND_INT;
        else if (s == SRC_PIN || s == SRC_PIN_INV) return KIND_EXT;
        else                                       return KIND_NONE;
    endfunction

    function automatic logic [PS_W-1:0] div_mask(input logic [DIV_W-1:0] d);
        logic [PS_W-1:0] one;
        one = {{(PS_W-1){1'b0}}, 1'b1};
        return (one << d) - one;
    endfunction

endpackage

// File: rtl/tclk_gate.sv
module tclk_gate
    import tclk_pkg::*;
(
    input  tclk_cfg_t           cfg,
    input  logic                sleep_i,
    input  logic                debug_i,
    input  logic [NUM_STOP-1:0] sleep_stop_i,
    output src_kind_e           kind,
    output logic                stop_sel,
    output logic                run
);
    logic [$clog2(NUM_STOP)-1:0] stop_idx;

    always_comb begin
        kind     = kind_of(cfg.src);
        stop_idx = (kind == KIND_INT) ? cfg.src[$clog2(NUM_STOP)-1:0]
                                      : $clog2(NUM_STOP)'(NUM_INT);
        stop_sel = sleep_stop_i[stop_idx];
        run      = !(sleep_i && stop_sel) && !(debug_i && !cfg.dbrun)
                   && (kind != KIND_NONE);
    end
endmodule

// File: rtl/tclk_prescale.sv
module tclk_prescale
    import tclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             adv,
    input  logic [DIV_W-1:0] div,
    output logic             pulse
);
    logic [PS_W-1:0] cnt;
    logic [PS_W-1:0] mask;

    always_comb begin
        mask  = div_mask(div);
        pulse = adv && (cnt == mask);
    end

    always_ff @(posedge clk) begin
        if (rst || clr)  cnt <= '0;
        else if (adv)    cnt <= pulse ? '0 : cnt + 1'b1;
    end

    AST_PS_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt <= mask);                                          // R2
    AST_PS_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (!adv && !clr) |=> $stable(cnt));                      // R8
endmodule

// File: rtl/tclk_extedge.sv
module tclk_extedge
    import tclk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    input  logic inv,
    input  logic pin,
    output logic pulse
);
    logic       sync1, sync2, hist;
    logic       rise, fall, qual;
    logic [1:0] dummy;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
            hist  <= 1'b0;
        end else begin
            sync1 <= pin;
            sync2 <= sync1;
            hist  <= sync2;
        end
    end

    always_comb begin
        rise  = sync2 && !hist;
        fall  = !sync2 && hist;
        qual  = en && (inv ? fall : rise);
        pulse = qual && (dummy == 2'(DUMMY_N));
    end

    always_ff @(posedge clk) begin
        if (rst || clr)                          dummy <= '0;
        else if (qual && dummy != 2'(DUMMY_N))   dummy <= dummy + 1'b1;
    end

    AST_DUMMY_RANGE: assert property (@(posedge clk) disable iff (rst)
        dummy <= 2'(DUMMY_N));                                 // R6
    AST_EXT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);                                     // R11
endmodule

// File: rtl/tclk_front.sv
module tclk_front
    import tclk_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [SRC_W-1:0]    cfg_src,
    input  logic [DIV_W-1:0]    cfg_div,
    input  logic                cfg_dbrun,
    input  logic                sleep_i,
    input  logic                debug_i,
    input  logic [NUM_STOP-1:0] sleep_stop_i,
    input  logic [NUM_INT-1:0]  src_tick_i,
    input  logic                ext_pin_i,
    output logic                cnt_en_o
);
    tclk_cfg_t  cfg;
    src_kind_e  kind;
    logic       stop_sel, run;
    logic       tick_sel, ps_adv, ps_pulse;
    logic       ext_en, ext_pulse;
    logic       cnt_en_q;

    always_ff @(posedge clk) begin
        if (rst)         cfg <= '{src: '0, div: '0, dbrun: 1'b0};
        else if (cfg_we) cfg <= '{src: cfg_src, div: cfg_div, dbrun: cfg_dbrun};
    end

    tclk_gate u_gate (
        .cfg          (cfg),
        .sleep_i      (sleep_i),
        .debug_i      (debug_i),
        .sleep_stop_i (sleep_stop_i),
        .kind         (kind),
        .stop_sel     (stop_sel),
        .run          (run)
    );

    always_comb begin
        tick_sel = 1'b0;
        for (int i = 0; i < NUM_INT; i++)
            if (cfg.src[IDX_W-1:0] == IDX_W'(i)) tick_sel = src_tick_i[i];
        ps_adv = run && (kind == KIND_INT) && tick_sel;
        ext_en = run && (kind == KIND_EXT);
    end

    tclk_prescale u_ps (
        .clk   (clk),
        .rst   (rst),
        .clr   (cfg_we),
        .adv   (ps_adv),
        .div   (cfg.div),
        .pulse (ps_pulse)
    );

    tclk_extedge u_ext (
        .clk   (clk),
        .rst   (rst),
        .clr   (cfg_we),
        .en    (ext_en),
        .inv   (cfg.src == SRC_PIN_INV),
        .pin   (ext_pin_i),
        .pulse (ext_pulse)
    );

    always_ff @(posedge clk) begin
        if (rst) cnt_en_q <= 1'b0;
        else     cnt_en_q <= ps_pulse || ext_pulse;
    end

    assign cnt_en_o = cnt_en_q;

    AST_SLEEP_GATE: assert property (@(posedge clk) disable iff (rst)
        (sleep_i && stop_sel) |=> !cnt_en_o);                  // R8
    AST_DEBUG_GATE: assert property (@(posedge clk) disable iff (rst)
        (debug_i && !cfg.dbrun) |=> !cnt_en_o);                // R10
    AST_NO_SOURCE: assert property (@(posedge clk) disable iff (rst)
        (kind == KIND_NONE) |=> !cnt_en_o);                    // R11
endmodule

// File: tb/tb_tclk_front.sv
`timescale 1ns/1ps
module tb_tclk_front;
    logic       clk = 0;
    logic       rst = 1;
    logic       cfg_we = 0;
    logic [2:0] cfg_src = 0;
    logic [3:0] cfg_div = 0;
    logic       cfg_dbrun = 0;
    logic       sleep_i = 0;
    logic       debug_i = 0;
    logic [4:0] sleep_stop_i = 0;
    logic [3:0] src_tick_i = 0;
    logic       ext_pin_i = 0;
    logic       cnt_en_o;

    int checks = 0;
    int failures = 0;
    int pcount = 0;
    bit done = 0;

    always #4 clk = ~clk;

    tclk_front dut (.*);

    always @(negedge clk) if (!rst && cnt_en_o) pcount++;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [2:0] s, input logic [3:0] d, input logic dr);
        @(posedge clk); #1;
        cfg_we = 1; cfg_src = s; cfg_div = d; cfg_dbrun = dr;
        @(posedge clk); #1;
        cfg_we = 0;
    endtask

    task automatic ticks(input logic [3:0] m, input int n);
        for (int i = 0; i < n; i++) begin
            src_tick_i = m;
            @(posedge clk); #1;
        end
        src_tick_i = 0;
        repeat (3) @(posedge clk);
        #1;
    endtask

    task automatic pin_to(input logic v);
        ext_pin_i = v;
        repeat (5) @(posedge clk);
        #1;
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 reset output", int'(cnt_en_o), 0);
        pcount = 0;
        ticks(4'b0001, 3);
        check("R1 default src0 div0", pcount, 3);
    endtask

    task automatic t_internal;
        write_cfg(3'd1, 4'd2, 0);
        pcount = 0;
        ticks(4'b1101, 8);
        check("R2 unselected ticks ignored", pcount, 0);
        ticks(4'b0010, 8);
        check("R2 div 4 on src1", pcount, 2);
        write_cfg(3'd3, 4'd4, 0);
        pcount = 0;
        ticks(4'b1000, 15);
        check("R2 div 16 before period", pcount, 0);
        ticks(4'b1000, 1);
        check("R2 div 16 at period", pcount, 1);
    endtask

    task automatic t_latency;
        write_cfg(3'd0, 4'd0, 0);
        @(posedge clk); #1;
        src_tick_i = 4'b0001;
        @(posedge clk); #1;
        src_tick_i = 0;
        @(negedge clk);
        check("R3 pulse after edge", int'(cnt_en_o), 1);
        @(negedge clk);
        check("R3 pulse one cycle", int'(cnt_en_o), 0);
    endtask

    task automatic t_ext_rise;
        write_cfg(3'd4, 4'd0, 0);
        pcount = 0;
        pin_to(1); pin_to(0);
        pin_to(1); pin_to(0);
        check("R6 two dummy edges", pcount, 0);
        pin_to(1);
        check("R4 third rise counts", pcount, 1);
        pin_to(0);
        check("R4 fall ignored", pcount, 1);
        pin_to(1); pin_to(0);
        check("R4 fourth rise", pcount, 2);
    endtask

    task automatic t_ext_fall;
        write_cfg(3'd5, 4'd0, 0);
        pcount = 0;
        pin_to(1); pin_to(0); pin_to(1); pin_to(0);
        check("R6 dummies on inverted", pcount, 0);
        pin_to(1);
        check("R5 rise ignored", pcount, 0);
        pin_to(0);
        check("R5 fall counts", pcount, 1);
    endtask

    task automatic t_ext_div;
        write_cfg(3'd4, 4'd3, 0);
        pcount = 0;
        for (int i = 0; i < 6; i++) begin pin_to(1); pin_to(0); end
        check("R7 div ignored on pin", pcount, 4);
    endtask

    task automatic t_sleep;
        write_cfg(3'd2, 4'd2, 0);
        pcount = 0;
        ticks(4'b0100, 2);
        sleep_stop_i = 5'b00100;
        sleep_i = 1;
        ticks(4'b0100, 10);
        check("R8 no pulse in sleep", pcount, 0);
        sleep_i = 0;
        ticks(4'b0100, 1);
        check("R8 phase held (3 of 4)", pcount, 0);
        ticks(4'b0100, 1);
        check("R8 resumes from held phase", pcount, 1);
        sleep_stop_i = 5'b11011;
        sleep_i = 1;
        pcount = 0;
        ticks(4'b0100, 8);
        check("R9 runs in sleep when stop 0", pcount, 2);
        sleep_i = 0;
        write_cfg(3'd4, 4'd0, 0);
        for (int i = 0; i < 2; i++) begin pin_to(1); pin_to(0); end
        sleep_stop_i = 5'b10000;
        sleep_i = 1;
        pcount = 0;
        pin_to(1); pin_to(0);
        check("R8 pin stop in sleep", pcount, 0);
        sleep_i = 0;
        pin_to(1); pin_to(0);
        check("R8 pin resumes", pcount, 1);
        sleep_stop_i = 0;
    endtask

    task automatic t_debug;
        write_cfg(3'd0, 4'd3, 0);
        pcount = 0;
        ticks(4'b0001, 5);
        debug_i = 1;
        ticks(4'b0001, 7);
        check("R10 halted in debug", pcount, 0);
        debug_i = 0;
        ticks(4'b0001, 2);
        check("R10 phase held in debug", pcount, 0);
        ticks(4'b0001, 1);
        check("R10 resumes after debug", pcount, 1);
        write_cfg(3'd0, 4'd1, 1);
        debug_i = 1;
        pcount = 0;
        ticks(4'b0001, 6);
        check("R10 run-in-debug set", pcount, 3);
        debug_i = 0;
    endtask

    task automatic t_nosrc;
        write_cfg(3'd6, 4'd0, 0);
        pcount = 0;
        ticks(4'b1111, 6);
        pin_to(1); pin_to(0); pin_to(1); pin_to(0); pin_to(1);
        check("R11 code 6 silent", pcount, 0);
        write_cfg(3'd7, 4'd0, 0);
        ticks(4'b1111, 6);
        pin_to(0); pin_to(1);
        check("R11 code 7 silent", pcount, 0);
        pin_to(0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        t_reset();
        t_internal();
        t_latency();
        t_ext_rise();
        t_ext_fall();
        t_ext_div();
        t_sleep();
        t_debug();
        t_nosrc();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog actual=1 expected=0");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule